// File: doc/BRIEF.md
# Three-Wire Serial Register Access Slave

This block lets an external host read and write a small file of byte-wide registers over three wires: an active-low select, a serial clock driven by the host, and one data line that both sides share. The host opens a transaction by pulling the select low. It then clocks in a 16-bit command word that carries a direction flag, a two-bit byte-count code and a 13-bit register address. One or more data bytes follow the command word. The slave drives the shared line only while it returns read data. At every other time the line belongs to the host.

All three pins are brought into the block's own system clock through a synchronizer and sampled there. The host's serial clock must therefore run several times slower than the system clock. After each data byte the register address counts down by one, so a multi-byte transfer walks through neighbouring registers in descending order. A special count code keeps the transfer going until the host raises the select. At the chip boundary the data line is split into an input, an output and an output enable, and the pad combines the three.

Top module: `spi3w_regslave`

## Requirements
- R1: While `cs_n` is high, activity on `sclk` and `sdio_in` changes no register, and `sdio_oe` is low.
- R2: After `cs_n` falls, the first 16 bits sampled form the command word. The order is: the direction flag (1 = read, 0 = write), then the count code high bit then low bit, then address bits 12 down to 0.
- R3: Data bits are sampled on rising `sclk` edges and returned most significant bit first, so each byte ends with bit 0.
- R4: On a read, `sdio_oe` rises after the first falling `sclk` edge that follows the command word. `sdio_out` changes only after falling `sclk` edges, and it holds a valid bit at every rising edge of the read data phase.
- R5: `sdio_oe` stays low during the command word and during write data. On a counted read it falls after the rising edge that samples the last bit.
- R6: Count code 00 means one data byte, 01 means two and 10 means three. Clocks after the last counted byte are ignored and write nothing.
- R7: Count code 11 streams bytes until `cs_n` rises.
- R8: After each byte the register address decrements by one, wrapping modulo 2^13.
- R9: Writes to an address at or above NUM_REGS are discarded, and reads from such an address return 0x00.
- R10: If `cs_n` rises before the eighth bit of a byte, that byte is not written and `sdio_oe` falls within the synchronizer latency.
- R11: After reset every register reads 0x00, and `sdio_oe` and `sdio_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low transaction select from the host |
| sclk | input | 1 | Serial clock from the host, idle low |
| sdio_in | input | 1 | Receive side of the shared data line |
| sdio_out | output | 1 | Transmit side of the shared data line |
| sdio_oe | output | 1 | High while the slave drives the shared data line |

## Verification
The bench builds the block with NUM_REGS = 16 and a two-stage synchronizer, and runs the serial clock at one twelfth of the system clock rate. With only sixteen registers, a short stream that starts near address 1 decrements through 0 and wraps to 0x1FFF. A single command can also name an address such as 100. Both cases exercise the out-of-range discard and zero read-back with only a few bytes. A full sixteen-byte stream read covers the whole file and checks the reset contents.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
   localparam int ADDR_W  = 13;
   localparam int DATA_W  = 8;
   localparam int CMD_W   = 16;
   localparam int CNT_W   = 2;

   typedef enum logic [1:0] {
      ST_CMD,
      ST_WR,
      ST_RD,
      ST_DONE
   } xfer_state_t;

   localparam logic [CNT_W-1:0] CNT_STREAM = 2'b11;
endpackage

// File: rtl/spi3w_sync.sv
module spi3w_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stg[g] <= RST_VAL;
         else if (g == 0)
            stg[g] <= d;
         else
            stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi3w_regfile.sv
module spi3w_regfile import spi3w_pkg::*; #(
   parameter int NUM_REGS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

   logic [DATA_W-1:0] mem [NUM_REGS];

   initial begin
      assert (NUM_REGS >= 1 && NUM_REGS <= (1 << ADDR_W))
         else $error("NUM_REGS must fit the 13-bit address space");
   end

   // one register per slot; an out-of-range address matches no slot and is dropped
   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (wr_en && ({1'b0, wr_addr} == (ADDR_W+1)'(g)))
            mem[g] <= wr_data;
      end
   end

   logic rd_hit;
   assign rd_hit  = ({1'b0, rd_addr} < LIMIT);
   assign rd_data = rd_hit ? mem[rd_addr[IDX_W-1:0]] : '0;
endmodule

// File: rtl/spi3w_regslave.sv
module spi3w_regslave import spi3w_pkg::*; #(
   parameter int NUM_REGS = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sclk,
   input  logic sdio_in,
   output logic sdio_out,
   output logic sdio_oe
);
   localparam int BIT_CW = $clog2(CMD_W);

   logic [2:0] pins_raw, pins_syn;
   logic       cs_s, sclk_s, din, sclk_q, sclk_rise, sclk_fall;

   assign pins_raw = {cs_n, sclk, sdio_in};

   spi3w_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_syn)
   );

   assign cs_s   = pins_syn[2];
   assign sclk_s = pins_syn[1];
   assign din    = pins_syn[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end
   assign sclk_rise = sclk_s & ~sclk_q;
   assign sclk_fall = ~sclk_s & sclk_q;

   xfer_state_t       state;
   logic [CMD_W-2:0]  cmd_sr;
   logic [BIT_CW-1:0] bit_cnt;
   logic [ADDR_W-1:0] cur_addr;
   logic [CNT_W-1:0]  left;
   logic              stream;
   logic [DATA_W-2:0] rx_sr;
   logic [DATA_W-1:0] tx_sr;
   logic              oe_q;
   logic [CMD_W-1:0]  cmd_word;
   logic              byte_end, last_byte;
   logic              wr_en;
   logic [DATA_W-1:0] rd_data;

   assign cmd_word  = {cmd_sr, din};
   assign byte_end  = (bit_cnt == BIT_CW'(DATA_W-1));
   assign last_byte = !stream && (left == '0);
   assign wr_en     = (state == ST_WR) && sclk_rise && byte_end && !cs_s;

   spi3w_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(cur_addr), .wr_data({rx_sr, din}),
      .rd_addr(cur_addr), .rd_data(rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_CMD;
         cmd_sr   <= '0;
         bit_cnt  <= '0;
         cur_addr <= '0;
         left     <= '0;
         stream   <= 1'b0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         oe_q     <= 1'b0;
      end else if (cs_s) begin
         state   <= ST_CMD;
         bit_cnt <= '0;
         oe_q    <= 1'b0;
      end else begin
         unique case (state)
            ST_CMD: if (sclk_rise) begin
               cmd_sr  <= cmd_word[CMD_W-2:0];
               bit_cnt <= bit_cnt + 1'b1;
               if (bit_cnt == BIT_CW'(CMD_W-1)) begin
                  cur_addr <= cmd_word[ADDR_W-1:0];
                  left     <= cmd_word[ADDR_W +: CNT_W];
                  stream   <= (cmd_word[ADDR_W +: CNT_W] == CNT_STREAM);
                  state    <= cmd_word[CMD_W-1] ? ST_RD : ST_WR;
                  bit_cnt  <= '0;
               end
            end
            ST_WR: if (sclk_rise) begin
               rx_sr   <= {rx_sr[DATA_W-3:0], din};
               bit_cnt <= bit_cnt + 1'b1;
               if (byte_end) begin
                  bit_cnt  <= '0;
                  cur_addr <= cur_addr - 1'b1;
                  left     <= left - 1'b1;
                  if (last_byte) state <= ST_DONE;
               end
            end
            ST_RD: begin
               if (sclk_fall) begin
                  oe_q  <= 1'b1;
                  tx_sr <= (bit_cnt == '0) ? rd_data : {tx_sr[DATA_W-2:0], 1'b0};
               end else if (sclk_rise) begin
                  bit_cnt <= bit_cnt + 1'b1;
                  if (byte_end) begin
                     bit_cnt  <= '0;
                     cur_addr <= cur_addr - 1'b1;
                     left     <= left - 1'b1;
                     if (last_byte) begin
                        state <= ST_DONE;
                        oe_q  <= 1'b0;
                     end
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sdio_oe  = oe_q;
   assign sdio_out = oe_q & tx_sr[DATA_W-1];

   // R1: deselect releases the line
   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !sdio_oe);
   // R4: the driver turns on only after a falling serial edge
   p_oe_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdio_oe) |-> $past(sclk_fall));
   // R4: the driven bit moves only after a falling serial edge
   p_out_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sdio_oe && !sclk_fall) |=> (!sdio_oe || $stable(sdio_out)));
   // R5: the driver turns off on a rising edge or on deselect
   p_oe_off_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sdio_oe) |-> $past(sclk_rise || cs_s));
   // R5: no driving during the command word or write data
   p_quiet_host_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CMD || state == ST_WR) |-> !sdio_oe);
endmodule

// File: tb/spi3w_regslave_tb.sv
module spi3w_regslave_tb_top;
   localparam int NREG = 16;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sclk = 1'b0;
   logic sdio_in = 1'b0;
   wire  sdio_out, sdio_oe;

   always #10 clk = ~clk;

   spi3w_regslave #(.NUM_REGS(NREG), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
      .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [7:0] model [NREG];
   logic [7:0] expq [$];
   logic [7:0] wbuf [0:15];
   bit mon_on = 1'b0;
   logic [7:0] mon_sr = '0;
   int mon_cnt = 0;
   string cur_req = "R3";

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pop expected read bytes as they complete on the line
   always @(posedge sclk) begin
      if (mon_on) begin
         check(sdio_oe === 1'b1, "R4", "line driven at read bit", int'(sdio_oe), 1);
         mon_sr = {mon_sr[6:0], sdio_out};
         mon_cnt++;
         if (mon_cnt == 8) begin
            mon_cnt = 0;
            if (expq.size() == 0)
               check(1'b0, "R6", "unexpected read byte", int'(mon_sr), 0);
            else begin
               logic [7:0] e;
               e = expq.pop_front();
               check(mon_sr == e, cur_req, "read byte", int'(mon_sr), int'(e));
            end
         end
      end
   end

   // driver: one framed transaction; abort_bits < 0 means no abort
   task automatic xfer(input bit rd, input logic [1:0] len, input logic [12:0] addr,
                       input int nbytes, input int abort_bits, input string req);
      logic [15:0] w;
      bit oe_bad;
      int nfull;
      w = {rd, len, addr};
      cur_req = req;
      nfull = (abort_bits >= 0) ? abort_bits / 8 : nbytes;
      for (int j = 0; j < nfull; j++) begin
         logic [12:0] a;
         a = addr - 13'(j);
         if (len == 2'b11 || j <= int'(len)) begin
            if (rd) expq.push_back((a < 13'(NREG)) ? model[a[3:0]] : 8'h00);
            else if (a < 13'(NREG)) model[a[3:0]] = wbuf[j];
         end
      end
      oe_bad = 1'b0;
      cs_n = 1'b0;
      hold(HALF);
      for (int i = 15; i >= 0; i--) begin
         sdio_in = w[i];
         hold(HALF);
         if (sdio_oe) oe_bad = 1'b1;
         sclk = 1'b1;
         hold(HALF);
         sclk = 1'b0;
      end
      check(!oe_bad, "R5", "line quiet in command word", int'(oe_bad), 0);
      if (rd) begin
         mon_cnt = 0;
         mon_on = 1'b1;
      end
      for (int b = 0; b < nbytes * 8; b++) begin
         if (abort_bits >= 0 && b == abort_bits) break;
         sdio_in = rd ? 1'b0 : wbuf[b / 8][7 - (b % 8)];
         hold(HALF);
         if (!rd && sdio_oe) oe_bad = 1'b1;
         sclk = 1'b1;
         hold(HALF);
         if (rd && len != 2'b11 && abort_bits < 0 && b == nbytes * 8 - 1)
            check(sdio_oe == 1'b0, "R5", "release after last bit", int'(sdio_oe), 0);
         sclk = 1'b0;
      end
      mon_on = 1'b0;
      if (!rd) check(!oe_bad, "R5", "line quiet in write data", int'(oe_bad), 0);
      hold(HALF);
      cs_n = 1'b1;
      hold(4);
      check(sdio_oe == 1'b0, (abort_bits >= 0) ? "R10" : "R1",
            "release after deselect", int'(sdio_oe), 0);
      hold(2 * HALF);
   endtask

   // serial activity while deselected
   task automatic idle_noise();
      logic [15:0] w;
      bit oe_bad;
      w = 16'h0005;
      oe_bad = 1'b0;
      for (int i = 0; i < 24; i++) begin
         sdio_in = (i < 16) ? w[15 - i] : 1'b1;
         hold(HALF);
         if (sdio_oe) oe_bad = 1'b1;
         sclk = 1'b1;
         hold(HALF);
         sclk = 1'b0;
      end
      check(!oe_bad, "R1", "line quiet while deselected", int'(oe_bad), 0);
      hold(2 * HALF);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      for (int k = 0; k < NREG; k++) model[k] = 8'h00;
      hold(5);
      check(sdio_oe == 1'b0, "R11", "oe in reset", int'(sdio_oe), 0);
      check(sdio_out == 1'b0, "R11", "out in reset", int'(sdio_out), 0);
      rst_n = 1'b1;
      hold(5);
      // R11: whole file reads zero after reset (16-byte stream from top)
      xfer(1'b1, 2'b11, 13'd15, 16, -1, "R11");
      // R2/R3: single byte write and read back
      wbuf[0] = 8'hA5;
      xfer(1'b0, 2'b00, 13'd5, 1, -1, "R2");
      xfer(1'b1, 2'b00, 13'd5, 1, -1, "R2");
      // R8: three-byte write descends 10, 9, 8
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      xfer(1'b0, 2'b10, 13'd10, 3, -1, "R8");
      xfer(1'b1, 2'b10, 13'd10, 3, -1, "R8");
      xfer(1'b1, 2'b00, 13'd9, 1, -1, "R3");
      // R6: two-byte count, third byte sent anyway must be ignored
      wbuf[0] = 8'h44; wbuf[1] = 8'h55; wbuf[2] = 8'h66;
      xfer(1'b0, 2'b01, 13'd4, 3, -1, "R6");
      xfer(1'b1, 2'b10, 13'd4, 3, -1, "R6");
      // R7: streaming write and read of five bytes
      for (int k = 0; k < 5; k++) wbuf[k] = 8'h81 + 8'(k);
      xfer(1'b0, 2'b11, 13'd15, 5, -1, "R7");
      xfer(1'b1, 2'b11, 13'd15, 5, -1, "R7");
      // R9: out-of-range address, and wrap past zero
      wbuf[0] = 8'hFF;
      xfer(1'b0, 2'b00, 13'd100, 1, -1, "R9");
      xfer(1'b1, 2'b00, 13'd100, 1, -1, "R9");
      wbuf[0] = 8'h9A; wbuf[1] = 8'h9B; wbuf[2] = 8'h9C;
      xfer(1'b0, 2'b11, 13'd1, 3, -1, "R9");
      xfer(1'b1, 2'b11, 13'd1, 3, -1, "R9");
      xfer(1'b1, 2'b00, 13'h1FFF, 1, -1, "R9");
      // R10: write aborted after five data bits, then read-back
      wbuf[0] = 8'hC3;
      xfer(1'b0, 2'b00, 13'd6, 1, 5, "R10");
      xfer(1'b1, 2'b00, 13'd6, 1, -1, "R10");
      // R10: read aborted after three data bits
      xfer(1'b1, 2'b00, 13'd5, 1, 3, "R10");
      // R1: clocks while deselected leave register 5 untouched
      idle_noise();
      xfer(1'b1, 2'b00, 13'd5, 1, -1, "R1");
      check(expq.size() == 0, "R3", "all expected bytes seen", expq.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule